// File: doc/BRIEF.md
# Threshold-Gated Memory-to-Stream Reader

This block drains a circular buffer held in external memory and turns it into a valid/ready output stream. It keeps the buffer's occupancy count, which the write side raises one word at a time through a push pulse. It also keeps the read position inside the region. When the count is above a programmable threshold, the block issues one read command at `BASE` plus the read position. It then waits for the memory's response, holds the returned word on the output until the consumer accepts it, and at that moment pulses its read strobe. The strobe lowers the count and advances the read position.

A non-zero threshold makes the stream wait until that many words are buffered plus one more. After that, single pushes and single pops alternate freely. Only one memory read is in flight at any time. The next command waits until the previous word has left the output.

Top module: `memStreamReader`

## Requirements
- R1: After reset the level is 0, and `cmdValid`, `outValid` and `rdStrobe` are all low.
- R2: No read command is raised while `level` is less than or equal to `readThreshold`. With `readThreshold` at 8, the first command follows the ninth push.
- R3: The n-th read command (counting from 0) carries address `BASE + (n mod DEPTH)`. The n-th output word is the memory response to that command. `cmdValid` and `cmdAddr` stay steady until `cmdReady` is seen.
- R4: At most one read is outstanding. A new command is raised only after the previous word was accepted on the output.
- R5: While `outValid` is high and `outReady` is low, `outValid` stays high and `outData` stays unchanged.
- R6: `rdStrobe` is high exactly in the cycle of an output handshake (`outValid` and `outReady` both high). That gives one pulse per delivered word.
- R7: `level` rises by 1 for each `wrPush` cycle and falls by 1 for each `rdStrobe` cycle. When both happen in the same cycle, it is unchanged. It never exceeds `DEPTH`.
- R8: The read position wraps from `DEPTH-1` back to 0, so with `DEPTH` = 32 the 33rd command addresses `BASE` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrPush | input | 1 | One word was written into the region this cycle |
| readThreshold | input | LVL_W (6) | Level that must be exceeded before reading |
| cmdValid | output | 1 | Read command request |
| cmdReady | input | 1 | Memory accepts the command |
| cmdAddr | output | ADDR_W (32) | Word address of the read |
| rspValid | input | 1 | Read data returned |
| rspReady | output | 1 | Block is waiting for read data |
| rspData | input | DATA_W (32) | Returned read data |
| outValid | output | 1 | Output word available |
| outReady | input | 1 | Consumer accepts the output word |
| outData | output | DATA_W (32) | Output word |
| rdStrobe | output | 1 | Read strobe, one pulse per delivered word |
| level | output | LVL_W (6) | Current buffer occupancy |

## Verification
The bench first fills the buffer exactly to a threshold of 8 and confirms that no command appears. A design that compares with "at or above" would read early here. It then runs about forty push/pop pairs, crossing the wrap point, so a pointer that fails to wrap or is offset from `BASE` shows up as a wrong address or wrong data. The consumer stalls the output and pushes in the same cycle as a pop. A design that drops or changes the held word, strobes more than once, or miscounts simultaneous up/down would be caught. The responder also flags any command raised while a word is still undelivered.

// File: rtl/memStreamReaderPkg.sv
package memStreamReaderPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_OUT
  } rdState_e;

  typedef struct packed {
    logic capture;   // latch the returned memory word
    logic advance;   // word delivered: move pointer, drop level
  } rdStrobes_t;
endpackage

// File: rtl/memStreamReaderCtrl.sv
module memStreamReaderCtrl
  import memStreamReaderPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       readable,
  input  logic       cmdReady,
  input  logic       rspValid,
  input  logic       outReady,
  output logic       cmdValid,
  output logic       rspReady,
  output logic       outValid,
  output rdStrobes_t strb
);
  rdState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (readable) stateNext = ST_CMD;
      ST_CMD:  if (cmdReady) stateNext = ST_WAIT;
      ST_WAIT: if (rspValid) stateNext = ST_OUT;
      ST_OUT:  if (outReady) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign cmdValid     = (state == ST_CMD);
  assign rspReady     = (state == ST_WAIT);
  assign outValid     = (state == ST_OUT);
  assign strb.capture = rspReady && rspValid;
  assign strb.advance = outValid && outReady;

  // R3: a raised command stays up until taken
  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid);

  // R4: no new command while a word waits on the output
  assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> !cmdValid);
endmodule

// File: rtl/memStreamReaderPath.sv
module memStreamReaderPath
  import memStreamReaderPkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BASE   = 8,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobes_t        strb,
  input  logic              wrPush,
  input  logic [LVL_W-1:0]  readThreshold,
  input  logic [DATA_W-1:0] rspData,
  output logic              readable,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] outData,
  output logic [LVL_W-1:0]  level
);
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] rdPtr;
  logic             pushOk;

  assign pushOk = wrPush && (level != LVL_FULL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level <= '0;
    end else begin
      case ({pushOk, strb.advance})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdPtr <= '0;
    else if (strb.advance) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             outData <= '0;
    else if (strb.capture) outData <= rspData;
  end

  assign readable = level > readThreshold;
  assign cmdAddr  = ADDR_W'(BASE) + ADDR_W'(rdPtr);

  // R7: occupancy never passes the region size
  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_FULL);

  // R8: each delivered word moves the read address on
  assert_addr_moves_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (cmdAddr != $past(cmdAddr)) || (DEPTH == 1));
endmodule

// File: rtl/memStreamReader.sv
module memStreamReader
  import memStreamReaderPkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BASE   = 8,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrPush,
  input  logic [LVL_W-1:0]  readThreshold,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdAddr,
  input  logic              rspValid,
  output logic              rspReady,
  input  logic [DATA_W-1:0] rspData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              rdStrobe,
  output logic [LVL_W-1:0]  level
);
  rdStrobes_t strb;
  logic       readable;

  memStreamReaderCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .readable (readable),
    .cmdReady (cmdReady),
    .rspValid (rspValid),
    .outReady (outReady),
    .cmdValid (cmdValid),
    .rspReady (rspReady),
    .outValid (outValid),
    .strb     (strb)
  );

  memStreamReaderPath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .DEPTH  (DEPTH)
  ) uPath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrPush        (wrPush),
    .readThreshold (readThreshold),
    .rspData       (rspData),
    .readable      (readable),
    .cmdAddr       (cmdAddr),
    .outData       (outData),
    .level         (level)
  );

  assign rdStrobe = strb.advance;

  // R2: a command only starts from a level above the threshold
  assert_cmd_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdValid) |-> $past(level) > $past(readThreshold));

  // R5: a stalled output word is held
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));
endmodule

// File: tb/tb_memStreamReader.sv
`timescale 1ns/1ps
module tb_memStreamReader;
  localparam int BASE  = 8;
  localparam int DEPTH = 32;

  logic        clk = 0;
  logic        rstN = 0;
  logic        wrPush = 0;
  logic [5:0]  readThreshold = 0;
  logic        cmdValid, cmdReady = 0;
  logic [31:0] cmdAddr;
  logic        rspValid = 0, rspReady;
  logic [31:0] rspData = 0;
  logic        outValid, outReady = 0;
  logic [31:0] outData;
  logic        rdStrobe;
  logic [5:0]  level;

  int total = 0, bad = 0;
  int cmdCount = 0, popCount = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  memStreamReader #(.BASE(BASE), .DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .wrPush(wrPush), .readThreshold(readThreshold),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr),
    .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .rdStrobe(rdStrobe), .level(level));

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder: accepts a command after a short delay, answers later
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (cmdValid) begin
        repeat (dly % 3) @(negedge clk);
        chk(cmdValid, "R3 command held", cmdValid, 1);
        chk(cmdAddr == 32'(BASE + (cmdCount % DEPTH)), "R3/R8 command address",
            cmdAddr, BASE + (cmdCount % DEPTH));
        chk(cmdCount == popCount, "R4 single outstanding", cmdCount, popCount);
        cmdReady = 1;
        rspData  = memWord(cmdAddr);
        @(negedge clk);
        cmdReady = 0;
        cmdCount++;
        repeat (dly % 4) @(negedge clk);
        rspValid = 1;
        @(negedge clk);
        rspValid = 0;
        dly++;
      end
    end
  end

  task automatic pushWords(input int n);
    wrPush = 1;
    repeat (n) @(negedge clk);
    wrPush = 0;
  endtask

  task automatic popWord(input int stall, input bit pushSame);
    int guard = 0;
    logic [31:0] held, expData;
    logic [5:0]  lvlBefore;
    while (!outValid && guard < 200) begin @(negedge clk); guard++; end
    chk(outValid, "R3 output appears", outValid, 1);
    expData = memWord(32'(BASE + (popCount % DEPTH)));
    for (int k = 0; k < stall; k++) begin
      chk(rdStrobe == 0, "R6 no strobe while stalled", rdStrobe, 0);
      held = outData;
      @(negedge clk);
      chk(outValid && outData == held, "R5 word held", outData, held);
    end
    lvlBefore = level;
    outReady = 1;
    wrPush   = pushSame;
    #1;
    chk(rdStrobe == 1, "R6 strobe on handshake", rdStrobe, 1);
    chk(outData == expData, "R3 output data", outData, expData);
    @(negedge clk);
    outReady = 0;
    wrPush   = 0;
    popCount++;
    chk(level == lvlBefore - 6'd1 + 6'(pushSame), "R7 level after pop",
        level, lvlBefore - 1 + pushSame);
    chk(rdStrobe == 0 && outValid == 0, "R6 single strobe", rdStrobe, 0);
  endtask

  task automatic testReset();
    chk(level == 0, "R1 level", level, 0);
    chk(!cmdValid && !outValid, "R1 valids", {cmdValid, outValid}, 0);
    chk(rdStrobe == 0, "R1 strobe", rdStrobe, 0);
  endtask

  task automatic testGating();
    readThreshold = 8;
    pushWords(8);
    chk(level == 8, "R7 level after pushes", level, 8);
    repeat (20) @(negedge clk);
    chk(cmdCount == 0 && !outValid, "R2 no read at threshold", cmdCount, 0);
    pushWords(1);
    popWord(0, 0);
    repeat (10) @(negedge clk);
    chk(cmdCount == 1, "R2 stops at threshold again", cmdCount, 1);
  endtask

  task automatic testFlowAndWrap();
    for (int i = 0; i < 40; i++) begin
      pushWords(1);
      popWord((i % 4 == 0) ? 3 : 0, (i % 7 == 3));
    end
    chk(popCount >= 41, "R8 crossed the wrap", popCount, 41);
  endtask

  task automatic testDrain();
    int guard = 0;
    readThreshold = 0;
    while (level != 0 && guard < 40) begin popWord(1, 0); guard++; end
    chk(level == 0, "R7 drained", level, 0);
    repeat (20) @(negedge clk);
    chk(cmdCount == popCount && !cmdValid, "R2 no read at empty", cmdCount, popCount);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testGating();
    testFlowAndWrap();
    testDrain();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule